// File: doc/BRIEF.md
# Bus Controller Instruction Sequencer

This block walks a list of bus controller instructions stored in a word-addressed RAM. Each list entry is two words long. The first is a checked instruction word and the second is a parameter. The host loads a list start address into a register. It then writes the start bit while the external run enable input is high. From that point the sequencer owns the instruction pointer. It fetches each instruction word through a synchronous RAM read port and validates it. It then either jumps, halts, or hands a message to a separate message engine through a request/done handshake.

Each instruction word has four fields: an odd parity bit, an opcode, a fixed check pattern and a condition field. A word that fails any check stops execution at once and sets a sticky trap flag. The same happens when a message parameter breaks the alignment rule. The flag records the cause and can raise an interrupt. Bus encoding, message transfer and frame timing sit outside this block.

Top module: `cmdlist_sequencer`

## Requirements
- R1: After a synchronous reset the pointer, base, trap enable, trap flag and cause all read 0, busy reads 0, and `trap_irq`, `msg_req` and `ram_rd` are low.
- R2: The host register map is: index 0 = control (bit 0 trap enable, bit 13 start, write-only, reads 0); index 1 = list base address; index 2 = current pointer (read-only); index 3 = status (bit 0 trap flag, bit 1 busy, bits 6:4 trap cause). A start is accepted only while idle, and only when `run_enable` is 1 in the cycle of the write. An accepted start loads the pointer from the base register and fetches the instruction word at that address.
- R3: A start write is ignored when `run_enable` is 0 or while the sequencer is busy. Outside a run, no RAM read is issued.
- R4: An instruction word is laid out as parity [15], opcode [14:10], check pattern [9:5] and condition [4:0]. It must have odd parity across all 16 bits. Otherwise the sequencer traps with cause 1.
- R5: A word with correct parity but a check pattern other than 01010 traps with cause 2.
- R6: Opcodes 00001 (message), 00010 (jump) and 00011 (halt) are defined. Any other opcode traps with cause 3. When several faults are present, parity is reported first, then the pattern, then the opcode.
- R7: A message entry requires a parameter with bits 2:0 equal to 0. If condition bit 4 is set (a terminal-to-terminal transfer), bits 3:0 must also be 0; violations trap with cause 4. A valid entry holds `msg_req` high, with `msg_ptr` equal to the parameter and `msg_rt2rt` equal to condition bit 4, until `msg_done`. The pointer then advances by 2.
- R8: A jump entry loads the pointer with its parameter and fetches from there without issuing a message.
- R9: A halt entry ends the run without a trap, with the pointer left at the halt entry.
- R10: On a trap the run ends in the cycle the fault is seen, busy drops, and the pointer is left at the offending entry.
- R11: The trap flag and cause stay set until the host writes 1 to status bit 0. Writing 0 there has no effect. `trap_irq` equals the trap flag ANDed with the trap enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_enable | input | 1 | External permission to start a run |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected register |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | ADDR_W | RAM word address |
| ram_rdata | input | 16 | RAM read data, valid one cycle after the strobe |
| msg_req | output | 1 | Message request to the message engine |
| msg_ptr | output | 16 | Message control block pointer |
| msg_rt2rt | output | 1 | Message is a terminal-to-terminal transfer |
| msg_done | input | 1 | Message engine finished the current request |
| trap_irq | output | 1 | Trap interrupt |

## Verification
A wrong decode or check shows up at the message port as a missing, extra or misplaced message pointer. It also shows up in the pointer and status registers at the end of the run, within a few cycles of the fetch that went wrong. The bench compares every message pointer, its terminal-to-terminal flag, the final pointer, the cause and the interrupt against a reference interpreter run over the same RAM image. A lost or stuck state shows as busy never dropping, or as a message request that never ends.

// File: rtl/cmdlist_pkg.sv
`timescale 1ns/1ps
package cmdlist_pkg;

    localparam int WORD_W = 16;

    localparam logic [4:0] OPC_EXEC      = 5'b00001;
    localparam logic [4:0] OPC_JUMP      = 5'b00010;
    localparam logic [4:0] OPC_HALT      = 5'b00011;
    localparam logic [4:0] CHECK_PATTERN = 5'b01010;

    localparam int CTRL_TRAPEN_BIT = 0;
    localparam int CTRL_START_BIT  = 13;
    localparam int STAT_FLAG_BIT   = 0;
    localparam int CC_PAIR_BIT     = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_BASE = 2'd1,
        REG_PTR  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_PARITY  = 3'd1,
        CAUSE_PATTERN = 3'd2,
        CAUSE_OPCODE  = 3'd3,
        CAUSE_ALIGN   = 3'd4
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OP,
        ST_CHK_OP,
        ST_RD_PRM,
        ST_CHK_PRM,
        ST_MSG
    } seq_state_e;

    typedef struct packed {
        logic       parity;
        logic [4:0] opc;
        logic [4:0] pattern;
        logic [4:0] cond;
    } opword_t;

    // Fault classification in priority order: parity, pattern, opcode.
    function automatic cause_e classify_word(input logic [WORD_W-1:0] raw);
        opword_t w;
        w = opword_t'(raw);
        if (^raw == 1'b0)
            return CAUSE_PARITY;
        else if (w.pattern != CHECK_PATTERN)
            return CAUSE_PATTERN;
        else if (w.opc != OPC_EXEC && w.opc != OPC_JUMP && w.opc != OPC_HALT)
            return CAUSE_OPCODE;
        return CAUSE_NONE;
    endfunction

    function automatic logic block_aligned(input logic [WORD_W-1:0] p, input logic pair);
        return pair ? (p[3:0] == 4'h0) : (p[2:0] == 3'h0);
    endfunction

endpackage

// File: rtl/cmdlist_opcheck.sv
`timescale 1ns/1ps
module cmdlist_opcheck
    import cmdlist_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cause_e            cause,
    output logic [4:0]        opc,
    output logic              pair
);
    opword_t fields;

    always_comb begin
        fields = opword_t'(word);
        cause  = classify_word(word);
        opc    = fields.opc;
        pair   = fields.cond[CC_PAIR_BIT];
    end
endmodule

// File: rtl/cmdlist_regs.sv
`timescale 1ns/1ps
module cmdlist_regs
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              run_enable,
    input  logic              busy,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              trap_set,
    input  cause_e            trap_cause_in,
    output logic              start_req,
    output logic [ADDR_W-1:0] base_addr,
    output logic              trap_en,
    output logic              trap_flag
);
    cause_e   cause_q;
    reg_sel_e sel;

    assign sel       = reg_sel_e'(host_addr);
    assign start_req = host_wr && sel == REG_CTRL && host_wdata[CTRL_START_BIT]
                       && run_enable && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            trap_en   <= 1'b0;
            trap_flag <= 1'b0;
            cause_q   <= CAUSE_NONE;
        end else begin
            if (host_wr && sel == REG_CTRL)
                trap_en <= host_wdata[CTRL_TRAPEN_BIT];
            if (host_wr && sel == REG_BASE)
                base_addr <= host_wdata[ADDR_W-1:0];
            if (trap_set) begin
                trap_flag <= 1'b1;
                cause_q   <= trap_cause_in;
            end else if (host_wr && sel == REG_STAT && host_wdata[STAT_FLAG_BIT]) begin
                trap_flag <= 1'b0;
                cause_q   <= CAUSE_NONE;
            end
        end
    end

    always_comb begin
        case (sel)
            REG_CTRL: host_rdata = {{(WORD_W-1){1'b0}}, trap_en};
            REG_BASE: host_rdata = WORD_W'(base_addr);
            REG_PTR:  host_rdata = WORD_W'(ptr);
            default:  host_rdata = {9'b0, cause_q, 2'b00, busy, trap_flag};
        endcase
    end
endmodule

// File: rtl/cmdlist_core.sv
`timescale 1ns/1ps
module cmdlist_core
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              ram_rd,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              msg_req,
    output logic [WORD_W-1:0] msg_ptr,
    output logic              msg_rt2rt,
    input  logic              msg_done,
    output logic [ADDR_W-1:0] ptr,
    output logic              busy,
    output logic              trap_set,
    output cause_e            trap_cause
);
    localparam logic [ADDR_W-1:0] PRM_OFS   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ENTRY_LEN = ADDR_W'(2);

    seq_state_e        state;
    logic [4:0]        opc_q;
    logic              pair_q;
    logic [WORD_W-1:0] prm_q;
    cause_e            op_cause;
    logic [4:0]        opc_w;
    logic              pair_w;
    logic              prm_ok;

    cmdlist_opcheck u_opcheck (
        .word  (ram_rdata),
        .cause (op_cause),
        .opc   (opc_w),
        .pair  (pair_w)
    );

    assign prm_ok    = block_aligned(ram_rdata, pair_q);
    assign busy      = state != ST_IDLE;
    assign ram_rd    = state == ST_RD_OP || state == ST_RD_PRM;
    assign ram_addr  = (state == ST_RD_PRM) ? ptr + PRM_OFS : ptr;
    assign msg_req   = state == ST_MSG;
    assign msg_ptr   = prm_q;
    assign msg_rt2rt = pair_q;

    always_comb begin
        trap_set   = 1'b0;
        trap_cause = CAUSE_NONE;
        if (state == ST_CHK_OP && op_cause != CAUSE_NONE) begin
            trap_set   = 1'b1;
            trap_cause = op_cause;
        end else if (state == ST_CHK_PRM && opc_q == OPC_EXEC && !prm_ok) begin
            trap_set   = 1'b1;
            trap_cause = CAUSE_ALIGN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            opc_q  <= '0;
            pair_q <= 1'b0;
            prm_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        ptr   <= base_addr;
                        state <= ST_RD_OP;
                    end
                end
                ST_RD_OP:  state <= ST_CHK_OP;
                ST_CHK_OP: begin
                    opc_q  <= opc_w;
                    pair_q <= pair_w;
                    if (op_cause != CAUSE_NONE || opc_w == OPC_HALT)
                        state <= ST_IDLE;
                    else
                        state <= ST_RD_PRM;
                end
                ST_RD_PRM: state <= ST_CHK_PRM;
                ST_CHK_PRM: begin
                    prm_q <= ram_rdata;
                    if (opc_q == OPC_JUMP) begin
                        ptr   <= ram_rdata[ADDR_W-1:0];
                        state <= ST_RD_OP;
                    end else if (!prm_ok) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_MSG;
                    end
                end
                ST_MSG: begin
                    if (msg_done) begin
                        ptr   <= ptr + ENTRY_LEN;
                        state <= ST_RD_OP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmdlist_sequencer.sv
`timescale 1ns/1ps
module cmdlist_sequencer
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_enable,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              ram_rd,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [15:0]       ram_rdata,
    output logic              msg_req,
    output logic [15:0]       msg_ptr,
    output logic              msg_rt2rt,
    input  logic              msg_done,
    output logic              trap_irq
);
    logic              start_req;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] ptr;
    logic              busy;
    logic              trap_set;
    cause_e            trap_cause;
    logic              trap_en;
    logic              trap_flag;

    cmdlist_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .host_wr       (host_wr),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .run_enable    (run_enable),
        .busy          (busy),
        .ptr           (ptr),
        .trap_set      (trap_set),
        .trap_cause_in (trap_cause),
        .start_req     (start_req),
        .base_addr     (base_addr),
        .trap_en       (trap_en),
        .trap_flag     (trap_flag)
    );

    cmdlist_core #(.ADDR_W(ADDR_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .base_addr  (base_addr),
        .ram_rd     (ram_rd),
        .ram_addr   (ram_addr),
        .ram_rdata  (ram_rdata),
        .msg_req    (msg_req),
        .msg_ptr    (msg_ptr),
        .msg_rt2rt  (msg_rt2rt),
        .msg_done   (msg_done),
        .ptr        (ptr),
        .busy       (busy),
        .trap_set   (trap_set),
        .trap_cause (trap_cause)
    );

    assign trap_irq = trap_flag && trap_en;
endmodule

// File: rtl/cmdlist_sequencer_chk.sv
`timescale 1ns/1ps
module cmdlist_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_wr,
    input logic [1:0]  host_addr,
    input logic [15:0] host_wdata,
    input logic        ram_rd,
    input logic        msg_req,
    input logic [15:0] msg_ptr,
    input logic        msg_rt2rt,
    input logic        msg_done,
    input logic        trap_irq,
    input logic        trap_flag,
    input logic        trap_en,
    input logic        busy
);
    // R7: a request stays up with a steady pointer until the engine answers
    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        msg_req && !msg_done |=> msg_req && $stable(msg_ptr) && $stable(msg_rt2rt));

    // R7: only aligned block pointers reach the message engine
    a_r7_ptr_aligned: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> msg_ptr[2:0] == 3'b000 && (!msg_rt2rt || !msg_ptr[3]));

    // R10: the run is over in the same cycle the trap flag rises
    a_r10_trap_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(trap_flag) |-> !busy && !msg_req);

    // R11: the interrupt needs both the flag and its enable
    a_r11_irq_gate: assert property (@(posedge clk) disable iff (rst)
        trap_irq |-> trap_flag && trap_en);

    // R11: the flag only falls on a host write of 1 to status bit 0
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        trap_flag && !(host_wr && host_addr == 2'd3 && host_wdata[0]) |=> trap_flag);

    // R3: no RAM traffic and no request outside a run
    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ram_rd && !msg_req);
endmodule

bind cmdlist_sequencer cmdlist_sequencer_chk u_chk (.*);

// File: tb/cmdlist_sequencer_tb.sv
`timescale 1ns/1ps
module cmdlist_sequencer_tb;
    import cmdlist_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_enable = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        ram_rd;
    logic [15:0] ram_addr;
    logic [15:0] ram_rdata = 16'h0;
    logic        msg_req;
    logic [15:0] msg_ptr;
    logic        msg_rt2rt;
    logic        msg_done = 1'b0;
    logic        trap_irq;

    always #2.5 clk = ~clk;

    cmdlist_sequencer u_dut (.*);

    logic [15:0] mem [256];
    always @(posedge clk) if (ram_rd) ram_rdata <= mem[ram_addr[7:0]];

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [15:0] obs_ptr [64];
    logic        obs_rt  [64];
    int          obs_n = 0;
    logic [15:0] exp_ptr [64];
    logic        exp_rt  [64];
    int          exp_n;
    logic [15:0] exp_final;
    int          exp_cause;
    bit          cur_trap_en = 1'b0;

    // message engine model
    initial begin
        forever begin
            @(negedge clk);
            if (msg_req) begin
                if (obs_n < 64) begin
                    obs_ptr[obs_n] = msg_ptr;
                    obs_rt[obs_n]  = msg_rt2rt;
                end
                obs_n++;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                msg_done = 1'b1;
                @(negedge clk);
                msg_done = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    function automatic logic [15:0] mk_op(input logic [4:0] opc, input logic [4:0] cond);
        logic [15:0] w;
        w = {1'b0, opc, 5'b01010, cond};
        w[15] = ~^w[14:0];
        return w;
    endfunction

    function automatic logic [15:0] fix_parity(input logic [15:0] w);
        logic [15:0] r;
        r = w;
        r[15] = ~^w[14:0];
        return r;
    endfunction

    // reference interpreter built from the requirements
    task automatic ref_run(input logic [15:0] base);
        logic [15:0] p, w, prm;
        p = base; exp_n = 0; exp_cause = 0;
        for (int s = 0; s < 300; s++) begin
            w = mem[p[7:0]];
            if (^w == 1'b0) begin exp_cause = 1; break; end
            if (w[9:5] != 5'b01010) begin exp_cause = 2; break; end
            if (w[14:10] == 5'd3) break;
            if (w[14:10] != 5'd1 && w[14:10] != 5'd2) begin exp_cause = 3; break; end
            prm = mem[8'(p[7:0] + 8'd1)];
            if (w[14:10] == 5'd2) begin p = prm; continue; end
            if (prm[2:0] != 3'd0 || (w[4] && prm[3])) begin exp_cause = 4; break; end
            exp_ptr[exp_n] = prm; exp_rt[exp_n] = w[4]; exp_n++;
            p = p + 16'd2;
        end
        exp_final = p;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        int guard = 0;
        do begin host_read(2'd3, s); guard++; end while (s[1] && guard < 4000);
    endtask

    task automatic run_and_check(input string tag, input logic [15:0] base);
        logic [15:0] r;
        host_write(2'd3, 16'h0001);
        obs_n = 0;
        host_write(2'd1, base);
        host_write(2'd0, 16'h2000 | 16'(cur_trap_en));
        wait_idle();
        ref_run(base);
        check(obs_n == exp_n, {tag, " R7 message count"}, obs_n, exp_n);
        for (int i = 0; i < exp_n && i < obs_n && i < 64; i++) begin
            check(obs_ptr[i] == exp_ptr[i], {tag, " R7 msg_ptr"}, obs_ptr[i], exp_ptr[i]);
            check(obs_rt[i] == exp_rt[i], {tag, " R7 msg_rt2rt"}, obs_rt[i], exp_rt[i]);
        end
        host_read(2'd2, r);
        check(r == exp_final, {tag, " R10 final pointer"}, r, exp_final);
        host_read(2'd3, r);
        check(r[0] == (exp_cause != 0), {tag, " R11 trap flag"}, r[0], exp_cause != 0);
        check(int'(r[6:4]) == exp_cause, {tag, " R4 trap cause"}, r[6:4], exp_cause);
        check(trap_irq == ((exp_cause != 0) && cur_trap_en), {tag, " R11 trap_irq"},
              trap_irq, (exp_cause != 0) && cur_trap_en);
    endtask

    task automatic gen_prog(input logic [15:0] base, input int k);
        for (int i = 0; i < k; i++) begin
            logic [7:0] a;
            int kind;
            logic [15:0] w;
            a = 8'(base + 16'(2 * i));
            kind = (i == k - 1) ? 3 : $urandom_range(0, 19);
            if (kind <= 11) begin
                logic rt;
                rt = ($urandom_range(0, 3) == 0);
                mem[a] = mk_op(5'd1, {rt, 4'($urandom_range(0, 15))});
                mem[8'(a + 1)] = 16'($urandom_range(0, 15) * 16);
                if ($urandom_range(0, 9) == 0) mem[8'(a + 1)] = mem[8'(a + 1)] | 16'h0008;
                if ($urandom_range(0, 14) == 0) mem[8'(a + 1)] = mem[8'(a + 1)] | 16'h0004;
            end else if (kind <= 15 && i < k - 2) begin
                mem[a] = mk_op(5'd2, 5'($urandom));
                mem[8'(a + 1)] = base + 16'(2 * $urandom_range(i + 1, k - 1));
            end else if (kind == 16) begin
                mem[a] = mk_op(5'd1, 5'd0) ^ 16'h8000;
            end else if (kind == 17) begin
                w = mk_op(5'd1, 5'd0);
                w[9:5] = 5'b10101;
                mem[a] = fix_parity(w);
            end else if (kind == 18) begin
                w = mk_op(5'd0, 5'd0);
                w[14:10] = ($urandom_range(0, 1) == 0) ? 5'd0 : 5'($urandom_range(4, 31));
                mem[a] = fix_parity(w);
            end else begin
                mem[a] = mk_op(5'd3, 5'd0);
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'hC0DE));
        for (int i = 0; i < 256; i++) mem[i] = mk_op(5'd3, 5'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        host_read(2'd2, r); check(r == 16'h0, "R1 pointer after reset", r, 0);
        host_read(2'd3, r); check(r == 16'h0, "R1 status after reset", r, 0);
        host_read(2'd0, r); check(r == 16'h0, "R1 control after reset", r, 0);
        check(!trap_irq && !msg_req && !ram_rd, "R1 outputs low after reset",
              {trap_irq, msg_req, ram_rd}, 0);

        // R7 R8 R9 directed list
        cur_trap_en = 1'b1;
        mem[8'h40] = mk_op(5'd1, 5'd0);  mem[8'h41] = 16'h0080;
        mem[8'h42] = mk_op(5'd1, 5'h10); mem[8'h43] = 16'h0090;
        mem[8'h44] = mk_op(5'd2, 5'd0);  mem[8'h45] = 16'h0050;
        mem[8'h50] = mk_op(5'd3, 5'd0);
        run_and_check("directed", 16'h0040);
        check(obs_n == 2 && obs_ptr[1] == 16'h0090 && obs_rt[1], "R7 rt2rt message", obs_ptr[1], 16'h0090);
        host_read(2'd2, r); check(r == 16'h0050, "R8 R9 jump then halt pointer", r, 16'h0050);
        host_read(2'd0, r); check(r == 16'h0001, "R2 control reads trap enable only", r, 1);
        host_read(2'd1, r); check(r == 16'h0040, "R2 base readback", r, 16'h0040);

        // R3 start with run_enable low
        run_enable = 1'b0;
        obs_n = 0;
        host_write(2'd1, 16'h0060);
        host_write(2'd0, 16'h2001);
        repeat (8) @(negedge clk);
        host_read(2'd3, r); check(r[1] == 1'b0, "R3 start ignored without enable", r[1], 0);
        host_read(2'd2, r); check(r == 16'h0050, "R3 pointer unchanged", r, 16'h0050);
        run_enable = 1'b1;

        // R4 R10 R11 parity fault after one message
        mem[8'h60] = mk_op(5'd1, 5'd0); mem[8'h61] = 16'h0020;
        mem[8'h62] = mk_op(5'd1, 5'd0) ^ 16'h8000;
        run_and_check("parity", 16'h0060);
        host_read(2'd3, r); check(r[6:4] == 3'd1, "R4 parity cause", r[6:4], 1);
        host_read(2'd2, r); check(r == 16'h0062, "R10 pointer at faulty entry", r, 16'h0062);
        check(trap_irq == 1'b1, "R11 irq with enable", trap_irq, 1);
        host_write(2'd3, 16'h0000);
        host_read(2'd3, r); check(r[0] == 1'b1, "R11 writing 0 keeps flag", r[0], 1);
        host_write(2'd3, 16'h0001);
        host_read(2'd3, r); check(r == 16'h0000, "R11 clear by writing 1", r, 0);
        check(trap_irq == 1'b0, "R11 irq cleared", trap_irq, 0);

        // R5 R6 pattern, opcode and priority
        begin
            logic [15:0] w;
            w = mk_op(5'd1, 5'd0); w[9:5] = 5'b01011;
            mem[8'h70] = fix_parity(w);
            run_and_check("pattern", 16'h0070);
            host_read(2'd3, r); check(r[6:4] == 3'd2, "R5 pattern cause", r[6:4], 2);
            mem[8'h70] = fix_parity(w) ^ 16'h8000;
            run_and_check("priority", 16'h0070);
            host_read(2'd3, r); check(r[6:4] == 3'd1, "R6 parity before pattern", r[6:4], 1);
            mem[8'h70] = mk_op(5'd0, 5'd0);
            run_and_check("opcode0", 16'h0070);
            host_read(2'd3, r); check(r[6:4] == 3'd3, "R6 undefined opcode", r[6:4], 3);
            mem[8'h70] = mk_op(5'd31, 5'd0);
            run_and_check("opcode31", 16'h0070);
        end

        // R7 alignment faults
        mem[8'h78] = mk_op(5'd1, 5'd0); mem[8'h79] = 16'h000C;
        run_and_check("misalign", 16'h0078);
        host_read(2'd3, r); check(r[6:4] == 3'd4, "R7 misaligned block", r[6:4], 4);
        mem[8'h78] = mk_op(5'd1, 5'h10); mem[8'h79] = 16'h0008;
        run_and_check("rt2rt misalign", 16'h0078);
        mem[8'h78] = mk_op(5'd1, 5'd0); mem[8'h79] = 16'h0008;
        mem[8'h7A] = mk_op(5'd3, 5'd0);
        run_and_check("eight aligned", 16'h0078);

        // R11 interrupt gated off
        cur_trap_en = 1'b0;
        mem[8'h78] = mk_op(5'd2, 5'd0) ^ 16'h8000;
        run_and_check("irq off", 16'h0078);
        check(trap_irq == 1'b0, "R11 irq masked", trap_irq, 0);
        cur_trap_en = 1'b1;

        // R3 start while busy is ignored
        mem[8'h40] = mk_op(5'd1, 5'd0);
        host_write(2'd3, 16'h0001);
        obs_n = 0;
        host_write(2'd1, 16'h0040);
        host_write(2'd0, 16'h2001);
        host_write(2'd1, 16'h0078);
        host_write(2'd0, 16'h2001);
        wait_idle();
        ref_run(16'h0040);
        check(obs_n == exp_n, "R3 restart while busy ignored", obs_n, exp_n);
        host_read(2'd2, r); check(r == exp_final, "R3 pointer after busy start", r, exp_final);

        // random lists
        for (int t = 0; t < 30; t++) begin
            logic [15:0] b;
            b = 16'(2 * $urandom_range(0, 40)) + 16'h0080;
            gen_prog(b, $urandom_range(2, 20));
            cur_trap_en = $urandom_range(0, 1);
            run_and_check("random R2", b);
        end

        finish_run();
    end
endmodule